// File: doc/BRIEF.md
# LCD Bias Drive Enable Sequencer

This block sequences the enables of the bias network that feeds a segment LCD driver's intermediate voltage levels. A high-resistance divider string stays on for as long as the display is enabled. Two independently timed windows sit beside it. One turns on a low-resistance string for extra drive. The other turns on the per-level bias buffers. Both windows open on every waveform-transition strobe from the LCD timing logic. Each then stays open for a programmed number of ticks of a prescaled timing clock.

The bias mode decides how many intermediate levels exist, and only the buffers of existing levels are enabled. The bias mode and both durations are captured only when a transition strobe arrives, so a rewrite in the middle of a window never changes an enable mid-window. The block also does three other jobs. It routes a 4-bit contrast trim code to the regulator while internal supply is selected. It gates the COM/SEG outputs with a display-enable bit. It passes the voltage-relation and regulation-ready flags through two-flop synchronizers.

Top module: `lcd_bias_seq`

## Requirements
- R1: `hi_str_en` equals `lcd_en` in every cycle.
- R2: A cycle with `xfer`=1 and `lcd_en`=1 raises `lowr_en` in the next cycle. It then stays high until `tick` has been high in `lowr_dur` clock cycles, and falls in the cycle after the last of those ticks.
- R3: The buffer window follows the same rule with its own count `buf_dur`, independently of the low-resistance window.
- R4: A duration value of 0, captured at a transition, keeps the corresponding enable low until the next transition.
- R5: A transition that arrives while a window is open reloads the full count. When `xfer` and `tick` are both high in the same cycle, the reload wins and that tick is not counted.
- R6: While the buffer window is open, `buf_en` equals the level mask of the captured bias mode: `bias_sel` 00 (static) gives 000, 01 (1/2) gives 001, 10 (1/3) gives 011, 11 (1/4) gives 111. Bit 0 is the first level used. While the window is closed, `buf_en` is 000.
- R7: `bias_sel`, `lowr_dur` and `buf_dur` are captured only in a cycle with `xfer`=1 and `lcd_en`=1. Changing them at any other time leaves both windows and `buf_en` unchanged.
- R8: `trim` equals `contrast` in the same cycle when `ext_supply`=0, and is 0 when `ext_supply`=1. The windows behave the same in both supply modes.
- R9: `out_gate` equals `lcd_en` AND `disp_en`.
- R10: `vrel_sync` and `vrdy_sync` equal `vrel_in` and `vrdy_in` as they were two clock cycles earlier.
- R11: While `lcd_en`=0, strobes are ignored. Both windows are cleared, so `lowr_en` and `buf_en` are low from the cycle after `lcd_en` is first seen low.
- R12: After synchronous reset, `lowr_en`, `buf_en`, `vrel_sync` and `vrdy_sync` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse from the prescaled timing clock |
| xfer | input | 1 | Waveform-transition strobe |
| lcd_en | input | 1 | LCD enable |
| disp_en | input | 1 | Display-enable bit for the COM/SEG outputs |
| bias_sel | input | 2 | Bias mode select |
| ext_supply | input | 1 | 1 selects external supply |
| contrast | input | 4 | Contrast code |
| lowr_dur | input | DUR_W | Low-resistance on-time, in ticks |
| buf_dur | input | DUR_W | Buffer on-time, in ticks |
| vrel_in | input | 1 | Asynchronous voltage-relation flag |
| vrdy_in | input | 1 | Asynchronous regulation-ready flag |
| hi_str_en | output | 1 | High-resistance string enable |
| lowr_en | output | 1 | Low-resistance string enable |
| buf_en | output | 3 | Per-level buffer enables |
| trim | output | 4 | Contrast trim code to the regulator |
| out_gate | output | 1 | COM/SEG output enable |
| vrel_sync | output | 1 | Synchronized voltage-relation flag |
| vrdy_sync | output | 1 | Synchronized regulation-ready flag |

## Verification
A transition strobe and a timing tick can land in the same clock cycle. In that cycle the counter must take the reload and ignore the decrement. The bench opens a window, spends part of its count, and then drives `xfer` and `tick` together for one cycle. It judges the result by counting the ticks that follow. The enable must stay high for exactly the full programmed duration, not one tick less.

// File: rtl/lcd_bias_pkg.sv
package lcd_bias_pkg;

    typedef enum logic [1:0] {
        BIAS_STATIC  = 2'b00,
        BIAS_HALF    = 2'b01,
        BIAS_THIRD   = 2'b10,
        BIAS_QUARTER = 2'b11
    } bias_mode_e;

    localparam int unsigned NUM_LVL = 3;
    localparam int unsigned NUM_WIN = 2;
    localparam int unsigned WIN_LOWR = 0;
    localparam int unsigned WIN_BUF  = 1;

    typedef logic [NUM_LVL-1:0] lvl_mask_t;

    // Levels that exist in each bias mode, lowest bit first.
    function automatic lvl_mask_t level_mask(bias_mode_e m);
        lvl_mask_t r;
        case (m)
            BIAS_STATIC:  r = 3'b000;
            BIAS_HALF:    r = 3'b001;
            BIAS_THIRD:   r = 3'b011;
            default:      r = 3'b111;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bias_sync2.sv
module bias_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bias_window.sv
module bias_window #(
    parameter int unsigned DUR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             xfer,
    input  logic             tick,
    input  logic [DUR_W-1:0] dur,
    output logic             active
);
    logic [DUR_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active <= 1'b0;
            remain <= '0;
        end else if (xfer) begin
            // reload has priority over a coincident tick
            remain <= dur;
            active <= (dur != '0);
        end else if (tick && active) begin
            remain <= remain - 1'b1;
            if (remain == {{(DUR_W-1){1'b0}}, 1'b1})
                active <= 1'b0;
        end
    end
endmodule

// File: rtl/lcd_bias_seq.sv
module lcd_bias_seq
    import lcd_bias_pkg::*;
#(
    parameter int unsigned DUR_W  = 4,
    parameter int unsigned CTST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              xfer,
    input  logic              lcd_en,
    input  logic              disp_en,
    input  logic [1:0]        bias_sel,
    input  logic              ext_supply,
    input  logic [CTST_W-1:0] contrast,
    input  logic [DUR_W-1:0]  lowr_dur,
    input  logic [DUR_W-1:0]  buf_dur,
    input  logic              vrel_in,
    input  logic              vrdy_in,
    output logic              hi_str_en,
    output logic              lowr_en,
    output logic [2:0]        buf_en,
    output logic [CTST_W-1:0] trim,
    output logic              out_gate,
    output logic              vrel_sync,
    output logic              vrdy_sync
);
    localparam int unsigned NSTAT = 2;

    bias_mode_e       mode_q;
    logic [DUR_W-1:0] dur_sel [NUM_WIN];
    logic [NUM_WIN-1:0] win_act;
    logic [NSTAT-1:0] stat_sync;

    assign dur_sel[WIN_LOWR] = lowr_dur;
    assign dur_sel[WIN_BUF]  = buf_dur;

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            bias_window #(.DUR_W(DUR_W)) u_win (
                .clk    (clk),
                .rst    (rst),
                .en     (lcd_en),
                .xfer   (xfer),
                .tick   (tick),
                .dur    (dur_sel[w]),
                .active (win_act[w])
            );
        end
    endgenerate

    // bias mode captured together with the durations
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= BIAS_STATIC;
        else if (lcd_en && xfer)
            mode_q <= bias_mode_e'(bias_sel);
    end

    bias_sync2 #(.W(NSTAT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({vrdy_in, vrel_in}),
        .q   (stat_sync)
    );

    always_comb begin
        hi_str_en = lcd_en;
        lowr_en   = win_act[WIN_LOWR];
        buf_en    = win_act[WIN_BUF] ? level_mask(mode_q) : '0;
        trim      = ext_supply ? '0 : contrast;
        out_gate  = lcd_en & disp_en;
        vrel_sync = stat_sync[0];
        vrdy_sync = stat_sync[1];
    end
endmodule

// File: rtl/lcd_bias_seq_chk.sv
module lcd_bias_seq_chk #(
    parameter int unsigned DUR_W  = 4,
    parameter int unsigned CTST_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer,
    input logic              lcd_en,
    input logic [DUR_W-1:0]  lowr_dur,
    input logic [DUR_W-1:0]  buf_dur,
    input logic              lowr_en,
    input logic [2:0]        buf_en,
    input logic              vrel_in,
    input logic              vrdy_in,
    input logic              vrel_sync,
    input logic              vrdy_sync
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R2
    lowr_open_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && lcd_en && lowr_dur != '0) |=> lowr_en);

    // R4
    zero_dur_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && lcd_en && buf_dur == '0) |=> (buf_en == 3'b000));

    // R6
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_en == 3'b000 || buf_en == 3'b001 || buf_en == 3'b011 || buf_en == 3'b111));

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(xfer) && $past(buf_en) != 3'b000 && buf_en != 3'b000) |-> $stable(buf_en));

    // R11
    lcd_off_chk: assert property (@(posedge clk) disable iff (rst)
        !lcd_en |=> (!lowr_en && buf_en == 3'b000));

    // R10
    sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (vrel_sync == $past(vrel_in, 2) && vrdy_sync == $past(vrdy_in, 2)));
endmodule

bind lcd_bias_seq lcd_bias_seq_chk #(.DUR_W(DUR_W), .CTST_W(CTST_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .xfer      (xfer),
    .lcd_en    (lcd_en),
    .lowr_dur  (lowr_dur),
    .buf_dur   (buf_dur),
    .lowr_en   (lowr_en),
    .buf_en    (buf_en),
    .vrel_in   (vrel_in),
    .vrdy_in   (vrdy_in),
    .vrel_sync (vrel_sync),
    .vrdy_sync (vrdy_sync)
);

// File: tb/lcd_bias_seq_test.sv
`timescale 1ns/1ps
module lcd_bias_seq_test;
    logic       clk = 1'b0;
    logic       rst, tick, xfer, lcd_en, disp_en, ext_supply, vrel_in, vrdy_in;
    logic [1:0] bias_sel;
    logic [3:0] contrast, lowr_dur, buf_dur, trim;
    logic       hi_str_en, lowr_en, out_gate, vrel_sync, vrdy_sync;
    logic [2:0] buf_en;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lcd_bias_seq uut (
        .clk(clk), .rst(rst), .tick(tick), .xfer(xfer), .lcd_en(lcd_en),
        .disp_en(disp_en), .bias_sel(bias_sel), .ext_supply(ext_supply),
        .contrast(contrast), .lowr_dur(lowr_dur), .buf_dur(buf_dur),
        .vrel_in(vrel_in), .vrdy_in(vrdy_in), .hi_str_en(hi_str_en),
        .lowr_en(lowr_en), .buf_en(buf_en), .trim(trim), .out_gate(out_gate),
        .vrel_sync(vrel_sync), .vrdy_sync(vrdy_sync)
    );

    // fields: bias(2) ext(1) contrast(4) lowr(4) buf(4) mask(3) trim(4)
    localparam int NV = 6;
    localparam logic [21:0] VEC [NV] = '{
        {2'b00, 1'b0, 4'h5, 4'd3, 4'd2, 3'b000, 4'h5},
        {2'b01, 1'b0, 4'hA, 4'd2, 4'd4, 3'b001, 4'hA},
        {2'b10, 1'b1, 4'h7, 4'd4, 4'd1, 3'b011, 4'h0},
        {2'b11, 1'b0, 4'hF, 4'd1, 4'd6, 3'b111, 4'hF},
        {2'b11, 1'b1, 4'h3, 4'd0, 4'd3, 3'b111, 4'h0},
        {2'b10, 1'b0, 4'h0, 4'd5, 4'd0, 3'b011, 4'h0}
    };

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic do_tick;
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic do_xfer;
        xfer = 1'b1;
        step();
        xfer = 1'b0;
    endtask

    initial begin
        rst = 1'b1; tick = 0; xfer = 0; lcd_en = 0; disp_en = 0; ext_supply = 0;
        vrel_in = 0; vrdy_in = 0; bias_sel = 2'b00; contrast = 4'h0;
        lowr_dur = 4'd0; buf_dur = 4'd0;
        step(); step(); step();
        // R12 reset state
        chk("R12 lowr_en", lowr_en, 0);
        chk("R12 buf_en", buf_en, 0);
        chk("R12 vrel_sync", vrel_sync, 0);
        chk("R12 vrdy_sync", vrdy_sync, 0);
        rst = 1'b0;
        lcd_en = 1'b1;
        step();
        // R1
        chk("R1 hi_str_en", hi_str_en, 1);

        // table of modes, durations and supply settings (R2 R3 R4 R6 R8)
        for (int v = 0; v < NV; v++) begin
            bias_sel   = VEC[v][21:20];
            ext_supply = VEC[v][19];
            contrast   = VEC[v][18:15];
            lowr_dur   = VEC[v][14:11];
            buf_dur    = VEC[v][10:7];
            do_xfer();
            chk("R8 trim", trim, VEC[v][3:0]);
            for (int k = 0; k < 9; k++) begin
                chk("R2 R4 lowr_en", lowr_en, (k < VEC[v][14:11]) ? 1 : 0);
                chk("R3 R6 buf_en", buf_en, (k < VEC[v][10:7]) ? VEC[v][6:4] : 0);
                do_tick();
            end
        end

        // R8 contrast rewritten while running takes effect at once
        ext_supply = 1'b0; contrast = 4'h9; #1;
        chk("R8 live contrast", trim, 4'h9);

        // R7 mid-window rewrites are held off until the next strobe
        ext_supply = 1'b0;
        bias_sel = 2'b11; lowr_dur = 4'd5; buf_dur = 4'd5;
        do_xfer();
        bias_sel = 2'b01; lowr_dur = 4'd1; buf_dur = 4'd1;
        do_tick(); do_tick();
        chk("R7 mask held", buf_en, 3'b111);
        chk("R7 lowr held", lowr_en, 1);
        do_xfer();
        chk("R7 new mask", buf_en, 3'b001);
        do_tick();
        chk("R7 new dur lowr", lowr_en, 0);
        chk("R7 new dur buf", buf_en, 0);

        // R5 retrigger mid-window
        bias_sel = 2'b10; lowr_dur = 4'd3; buf_dur = 4'd3;
        do_xfer();
        do_tick(); do_tick();
        do_xfer();
        do_tick(); do_tick();
        chk("R5 retrigger still on", lowr_en, 1);
        do_tick();
        chk("R5 retrigger off", lowr_en, 0);

        // R5 strobe and tick in the same cycle: reload wins
        do_xfer();
        do_tick(); do_tick();
        xfer = 1'b1; tick = 1'b1;
        step();
        xfer = 1'b0; tick = 1'b0;
        do_tick(); do_tick();
        chk("R5 collision lowr", lowr_en, 1);
        chk("R5 collision buf", buf_en, 3'b011);
        do_tick();
        chk("R5 collision end", lowr_en, 0);

        // R9 output gate
        disp_en = 1'b1; #1;
        chk("R9 gate on", out_gate, 1);
        disp_en = 1'b0; #1;
        chk("R9 gate off", out_gate, 0);

        // R11 LCD disable clears windows and ignores strobes
        disp_en = 1'b1;
        do_xfer();
        chk("R11 open before", lowr_en, 1);
        lcd_en = 1'b0;
        step();
        chk("R11 lowr cleared", lowr_en, 0);
        chk("R11 buf cleared", buf_en, 0);
        chk("R1 hi_str off", hi_str_en, 0);
        chk("R9 gate forced", out_gate, 0);
        do_xfer();
        chk("R11 strobe ignored", lowr_en, 0);
        lcd_en = 1'b1;

        // R10 two-cycle synchronizer latency
        vrel_in = 1'b1; vrdy_in = 1'b1;
        step();
        chk("R10 vrel one cycle", vrel_sync, 0);
        chk("R10 vrdy one cycle", vrdy_sync, 0);
        step();
        chk("R10 vrel two cycles", vrel_sync, 1);
        chk("R10 vrdy two cycles", vrdy_sync, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule